// File: doc/BRIEF.md
# Input Change Interrupt Controller

This block watches a small group of general-purpose input pins and records each change of level on them. It then merges that record with status bits from other sources into a single active-low interrupt line. Each pin is brought into the clock domain through a flop chain. A change is any difference between two consecutive synchronized samples, so rising and falling edges count alike.

A CPU reaches four registers over a synchronous read/write bus. Reads of the change register have a clear-on-read side effect.

- **Change register (address 0).** The upper half holds the latched change flags and the lower half shows the live synchronized pin levels. Reading it clears the flags and the summary status bit.
- **Status register (address 1).** The top bit is a summary of enabled input changes. The lower bits copy external source signals every cycle.
- **Mask register (address 2).** It selects which status bits may drive the interrupt line.
- **Enable field (address 3).** It selects which inputs may set the summary bit.

Top module: `inchg_irq_ctrl`

## Requirements
- R1: After reset, the change register, status register, mask and enable field all read 0x00 (pins held low), and `irq_n` is 1.
- R2: A level change on input i, rising or falling, sets change-register bit 4+i. The bit reads as 1 three clock edges after the pin changes.
- R3: Bits 3:0 of the change register show the current synchronized level of inputs 3:0 and are not latched.
- R4: A read strobe at address 0 clears change-register bits 7:4 and status bit 7 at that clock edge.
- R5: Status bit 7 is set by a change on input i only when enable bit i (address 3, bit i) is 1. A change on a disabled input sets its change flag but leaves status bit 7 unchanged.
- R6: Status bits 6:0 take the value of `src_stat` one clock edge after it is presented.
- R7: `irq_n` is 0 exactly when some status bit and the mask bit at the same position (address 2) are both 1.
- R8: A read of the status register (address 1) returns the unmasked status and has no side effect.
- R9: If an input change is detected in the same cycle as a clearing read of address 0, the flag for that input, and status bit 7 if that input is enabled, end up set.
- R10: Writes to addresses 0 and 1 have no effect. Only the mask and the enable field are writable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | 4 | Asynchronous input pins |
| src_stat | input | 7 | Other interrupt sources for status bits 6:0 |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe (side effects at address 0) |
| addr | input | 2 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr`, combinational |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The bench builds the block with its default values: four inputs and a two-flop synchronizer. With these values the three-edge latency from pin to flag is fixed and known, so the bench can place a clearing read exactly on the cycle in which a change is detected and exercise the race in R9. The eight-bit register layout then matches the field positions given in the requirements. A vector table sweeps mask and source combinations for the interrupt line. Directed steps cover enabled and disabled inputs, both edge directions and ignored writes.

// File: rtl/inchg_pkg.sv
package inchg_pkg;
  typedef enum logic [1:0] {
    ADR_CHG  = 2'd0,
    ADR_STAT = 2'd1,
    ADR_MASK = 2'd2,
    ADR_EN   = 2'd3
  } reg_addr_e;

  // nonzero when any bit is set in both operands
  function automatic logic both_set(input logic [31:0] a, input logic [31:0] b);
    return |(a & b);
  endfunction

  // new flag value: a clearing read keeps only events of this cycle
  function automatic logic [31:0] flag_next(input logic [31:0] cur,
                                            input logic [31:0] evt,
                                            input logic        clr);
    return clr ? evt : (cur | evt);
  endfunction
endpackage

// File: rtl/inchg_sync.sv
module inchg_sync #(
  parameter int NUM_IN = 4,
  parameter int STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_IN-1:0] pin,
  output logic [NUM_IN-1:0] level,
  output logic [NUM_IN-1:0] chg
);
  generate
    for (genvar i = 0; i < NUM_IN; i++) begin : g_pin
      logic [STAGES-1:0] chain;
      logic              prev;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          chain <= '0;
          prev  <= 1'b0;
        end else begin
          chain <= {chain[STAGES-2:0], pin[i]};
          prev  <= chain[STAGES-1];
        end
      end
      assign level[i] = chain[STAGES-1];
      assign chg[i]   = chain[STAGES-1] ^ prev;
    end
  endgenerate
endmodule

// File: rtl/inchg_flags.sv
module inchg_flags
  import inchg_pkg::*;
#(
  parameter int NUM_IN = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_IN-1:0] chg,
  input  logic [NUM_IN-1:0] en,
  input  logic              rd_clr,
  output logic [NUM_IN-1:0] flags,
  output logic              summ
);
  logic              hit;
  logic [31:0]       fl_n32;
  logic [NUM_IN-1:0] flags_n;

  assign hit     = both_set(32'(chg), 32'(en));
  assign fl_n32  = flag_next(32'(flags), 32'(chg), rd_clr);
  assign flags_n = fl_n32[NUM_IN-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags <= '0;
      summ  <= 1'b0;
    end else begin
      flags <= flags_n;
      summ  <= rd_clr ? hit : (summ | hit);
    end
  end

  // R4
  flags_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && chg == '0) |=> (flags == '0 && !summ));

  // R9
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chg != '0) |=> ((flags & $past(chg)) == $past(chg)));

  // R5
  en_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!summ && (chg & en) == '0) |=> !summ);
endmodule

// File: rtl/inchg_stat.sv
module inchg_stat
  import inchg_pkg::*;
#(
  parameter int STAT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STAT_W-2:0] src,
  input  logic              summ,
  input  logic [STAT_W-1:0] mask,
  output logic [STAT_W-1:0] status,
  output logic              irq_n
);
  logic [STAT_W-2:0] low_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) low_q <= '0;
    else        low_q <= src;
  end

  assign status = {summ, low_q};
  assign irq_n  = ~both_set(32'(status), 32'(mask));

  // R6
  stat_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (status[STAT_W-2:0] == $past(src)));

  // R7
  irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '0) |-> irq_n);
endmodule

// File: rtl/inchg_irq_ctrl.sv
module inchg_irq_ctrl
  import inchg_pkg::*;
#(
  parameter int NUM_IN      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_IN-1:0]     pin_in,
  input  logic [2*NUM_IN-2:0]   src_stat,
  input  logic                  wr_en,
  input  logic                  rd_en,
  input  logic [1:0]            addr,
  input  logic [2*NUM_IN-1:0]   wdata,
  output logic [2*NUM_IN-1:0]   rdata,
  output logic                  irq_n
);
  localparam int REG_W = 2 * NUM_IN;

  logic [NUM_IN-1:0] level, chg, flags, en_q;
  logic [REG_W-1:0]  mask_q, status;
  logic              summ, rd_clr;

  assign rd_clr = rd_en && (addr == ADR_CHG);

  inchg_sync #(.NUM_IN(NUM_IN), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin(pin_in), .level(level), .chg(chg));

  inchg_flags #(.NUM_IN(NUM_IN)) u_flags (
    .clk(clk), .rst_n(rst_n), .chg(chg), .en(en_q), .rd_clr(rd_clr),
    .flags(flags), .summ(summ));

  inchg_stat #(.STAT_W(REG_W)) u_stat (
    .clk(clk), .rst_n(rst_n), .src(src_stat), .summ(summ), .mask(mask_q),
    .status(status), .irq_n(irq_n));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      en_q   <= '0;
    end else if (wr_en) begin
      if (addr == ADR_MASK) mask_q <= wdata;
      if (addr == ADR_EN)   en_q   <= wdata[NUM_IN-1:0];
    end
  end

  always_comb begin
    case (addr)
      ADR_CHG:  rdata = {flags, level};
      ADR_STAT: rdata = status;
      ADR_MASK: rdata = mask_q;
      default:  rdata = {{(REG_W-NUM_IN){1'b0}}, en_q};
    endcase
  end

  // R8
  stat_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == ADR_STAT && chg == '0) |=> (summ == $past(summ)));
endmodule

// File: tb/inchg_irq_ctrl_tb.sv
module inchg_irq_ctrl_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 0, rst_n = 0;
  logic [3:0] pin_in = 0;
  logic [6:0] src_stat = 0;
  logic       wr_en = 0, rd_en = 0;
  logic [1:0] addr = 0;
  logic [7:0] wdata = 0;
  logic [7:0] rdata;
  logic       irq_n;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  inchg_irq_ctrl u_dut (.clk(clk), .rst_n(rst_n), .pin_in(pin_in), .src_stat(src_stat),
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata), .irq_n(irq_n));

  always #(CLK_PERIOD/2) clk = ~clk;

  // {expected irq_n, src_stat[6:0], mask[7:0]}
  localparam logic [15:0] VEC [7] = '{
    {1'b1, 7'h00, 8'hFF}, {1'b0, 7'h01, 8'h01}, {1'b1, 7'h01, 8'h02},
    {1'b0, 7'h40, 8'h40}, {1'b1, 7'h2A, 8'h15}, {1'b0, 7'h2A, 8'h08},
    {1'b1, 7'h7F, 8'h80}};

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic peek(input logic [1:0] a, output logic [7:0] v);
    addr = a; #1; v = rdata;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic clr_read(output logic [7:0] v);
    @(negedge clk); rd_en = 1; addr = 2'd0; #1; v = rdata;
    @(negedge clk); rd_en = 0;
  endtask

  task automatic set_pins(input logic [3:0] p);
    @(negedge clk); pin_in = p;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      peek(2'(a), v); chk("R1 reg", v, 8'h00);
    end
    chk("R1 irq_n", {7'd0, irq_n}, 8'h01);

    // R6 R7 table
    for (int i = 0; i < 7; i++) begin
      wr(2'd2, VEC[i][7:0]);
      @(negedge clk); src_stat = VEC[i][14:8];
      @(negedge clk);
      chk("R7 irq_n", {7'd0, irq_n}, {7'd0, VEC[i][15]});
      peek(2'd1, v); chk("R6 status", v, {1'b0, VEC[i][14:8]});
    end
    src_stat = 0;
    wr(2'd2, 8'h00);
    wr(2'd3, 8'h01);

    // R2 R3 R5: disabled input 1 rises
    set_pins(4'b0010);
    peek(2'd0, v); chk("R2 R3 rise", v, 8'h22);
    peek(2'd1, v); chk("R5 disabled", v, 8'h00);

    // enabled input 0 rises
    set_pins(4'b0011);
    peek(2'd0, v); chk("R2 R3 both", v, 8'h33);
    peek(2'd1, v); chk("R5 enabled", v, 8'h80);
    wr(2'd2, 8'h80);
    @(negedge clk);
    chk("R7 summary irq", {7'd0, irq_n}, 8'h00);

    // R8 status read has no side effect
    @(negedge clk); rd_en = 1; addr = 2'd1; #1; v = rdata;
    chk("R8 read value", v, 8'h80);
    @(negedge clk); rd_en = 0;
    peek(2'd1, v); chk("R8 after read", v, 8'h80);

    // R4 clearing read
    clr_read(v); chk("R4 read value", v, 8'h33);
    peek(2'd0, v); chk("R4 flags cleared", v, 8'h03);
    peek(2'd1, v); chk("R4 status7 cleared", v, 8'h00);
    chk("R4 irq released", {7'd0, irq_n}, 8'h01);

    // R2 falling on disabled input
    set_pins(4'b0001);
    peek(2'd0, v); chk("R2 fall", v, 8'h21);
    peek(2'd1, v); chk("R5 fall disabled", v, 8'h00);
    clr_read(v);
    peek(2'd0, v); chk("R4 clear again", v, 8'h01);

    // R9 change detected in the cycle of a clearing read
    @(negedge clk); pin_in = 4'b0000;
    @(negedge clk);
    @(negedge clk); rd_en = 1; addr = 2'd0;
    @(negedge clk); rd_en = 0;
    peek(2'd0, v); chk("R9 flag kept", v, 8'h10);
    peek(2'd1, v); chk("R9 status7 kept", v, 8'h80);

    // R10 writes to read-only addresses ignored
    wr(2'd0, 8'hFF);
    wr(2'd1, 8'hFF);
    peek(2'd0, v); chk("R10 chg write", v, 8'h10);
    peek(2'd1, v); chk("R10 stat write", v, 8'h80);
    peek(2'd2, v); chk("R10 mask readback", v, 8'h80);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule